// File: doc/BRIEF.md
# Software Semaphore Arbiter

This block is a hardware semaphore that up to four software agents share through one 32-bit register. An agent posts a request by writing a 1 to its own set position, and withdraws the request or gives up ownership by writing a 1 to its own clear position. Because posting and withdrawing use separate bit groups, agents can share the register without a read-modify-write. The block keeps a pending flag for each agent and makes exactly one pending agent the owner. The owner keeps its grant until it writes its own clear bit. There is no timeout.

The register is read combinationally. It shows the owner flags and the pending flags. The set and clear positions always read back as zero. The bus side is a plain write strobe with write data, plus a read data bus.

The grant logic is a two-state machine:

- `ST_FREE`: nobody owns the semaphore.
- `ST_OWNED`: a one-hot owner register is valid.

It has two transitions:

- GRANT (`ST_FREE` to `ST_OWNED`): taken on the first edge at which some request is pending and is not being cleared in that same cycle. The owner is the lowest-numbered such requester.
- RELEASE (`ST_OWNED` to `ST_FREE`): taken on the edge at which the owner's clear bit is written.

Every other case holds the current state.

Top module: `sw_sem_arbiter`

## Requirements
- R1: A write with bit i (i = 0..3) set marks requester i as pending from the next clock edge. Bits written as 0 in positions 0..3 change nothing.
- R2: A write with bit 4+i set clears requester i's pending flag at the next clock edge.
- R3: If one write sets both bit i and bit 4+i, the clear takes priority and requester i ends up not pending.
- R4: Read data bits 12+i show requester i's pending flag.
- R5: Read data bits 8+i show requester i's owner flag. At most one owner flag is ever 1.
- R6: When several requests are pending and nobody owns the semaphore, the lowest-numbered pending requester becomes the owner.
- R7: A grant appears one clock edge after a request becomes pending. A request that was set and then cleared before that edge is never granted.
- R8: While an owner exists, it stays the owner across any write that does not set its own clear bit (bit 4+owner). This includes sets and clears from other requesters, and writes to bits 8..31.
- R9: Writing the owner's clear bit drops its owner flag at the next edge. If any requests are still pending, the next grant follows one edge later.
- R10: Reset (rst_n low) clears all pending and owner flags.
- R11: Read data bits 0..7 and 16..31 always read 0. Writes to bits 8..31 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_data | input | 32 | Write data: bits 0..3 set, bits 4..7 clear |
| rd_data | output | 32 | Read data: bits 8..11 owner, bits 12..15 pending |

## Verification
The assertions assume the following about the inputs:
- `wr_en` is a clean single-cycle strobe.
- Reset is held for at least one edge before it is released, so every `$past` term refers to reset-state or later values.
- Nothing else is assumed: any write data in any state is legal.

The stimulus stays within these assumptions:
- Each scenario starts from a fresh multi-cycle reset.
- Inputs are driven only on the falling edge.
- It sweeps all 16 starting request patterns, combined with all 256 values of the low byte in the following write.
- The upper bits of that write carry a pattern that tries to overwrite the read-only fields, which exercises the ignored-write cases.

// File: rtl/sw_sem_pkg.sv
package sw_sem_pkg;

    typedef enum logic [0:0] {
        ST_FREE  = 1'b0,
        ST_OWNED = 1'b1
    } sem_state_e;

endpackage

// File: rtl/sw_sem_req_bank.sv
module sw_sem_req_bank #(
    parameter int NREQ = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [NREQ-1:0] set_vec,
    input  logic [NREQ-1:0] clr_vec,
    output logic [NREQ-1:0] pend
);

    for (genvar g = 0; g < NREQ; g++) begin : g_req
        logic flag_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_q <= 1'b0;
            end else if (wr_en && clr_vec[g]) begin
                flag_q <= 1'b0;
            end else if (wr_en && set_vec[g]) begin
                flag_q <= 1'b1;
            end
        end

        assign pend[g] = flag_q;
    end

endmodule

// File: rtl/sw_sem_pick.sv
module sw_sem_pick #(
    parameter int NREQ = 4
) (
    input  logic [NREQ-1:0] cand,
    output logic [NREQ-1:0] sel
);

    always_comb begin
        sel = '0;
        for (int i = NREQ - 1; i >= 0; i--) begin
            if (cand[i]) begin
                sel    = '0;
                sel[i] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/sw_sem_grant_fsm.sv
module sw_sem_grant_fsm
    import sw_sem_pkg::*;
#(
    parameter int NREQ = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [NREQ-1:0] clr_vec,
    input  logic [NREQ-1:0] pend,
    output logic [NREQ-1:0] won
);

    sem_state_e      state_q, state_d;
    logic [NREQ-1:0] owner_q, owner_d;
    logic [NREQ-1:0] clr_eff;
    logic [NREQ-1:0] cand;
    logic [NREQ-1:0] pick;

    assign clr_eff = wr_en ? clr_vec : '0;
    assign cand    = pend & ~clr_eff;

    sw_sem_pick #(.NREQ(NREQ)) u_pick (
        .cand (cand),
        .sel  (pick)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FREE;
            owner_q <= '0;
        end else begin
            state_q <= state_d;
            owner_q <= owner_d;
        end
    end

    always_comb begin
        state_d = state_q;
        owner_d = owner_q;
        unique case (state_q)
            ST_FREE: begin
                if (|cand) begin
                    state_d = ST_OWNED;
                    owner_d = pick;
                end
            end
            ST_OWNED: begin
                if (|(clr_eff & owner_q)) begin
                    state_d = ST_FREE;
                    owner_d = '0;
                end
            end
            default: begin
                state_d = ST_FREE;
                owner_d = '0;
            end
        endcase
    end

    always_comb begin
        won = (state_q == ST_OWNED) ? owner_q : '0;
    end

endmodule

// File: rtl/sw_sem_arbiter.sv
module sw_sem_arbiter #(
    parameter int NREQ  = 4,
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data
);

    localparam int SET_LSB  = 0;
    localparam int CLR_LSB  = NREQ;
    localparam int WON_LSB  = 2 * NREQ;
    localparam int PEND_LSB = 3 * NREQ;

    logic [NREQ-1:0] set_vec;
    logic [NREQ-1:0] clr_vec;
    logic [NREQ-1:0] pend;
    logic [NREQ-1:0] won;
    logic            unused_hi;

    assign set_vec   = wr_data[SET_LSB +: NREQ];
    assign clr_vec   = wr_data[CLR_LSB +: NREQ];
    assign unused_hi = ^wr_data[REG_W-1:WON_LSB];

    sw_sem_req_bank #(.NREQ(NREQ)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .pend    (pend)
    );

    sw_sem_grant_fsm #(.NREQ(NREQ)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .clr_vec (clr_vec),
        .pend    (pend),
        .won     (won)
    );

    always_comb begin
        rd_data                     = '0;
        rd_data[WON_LSB +: NREQ]    = won;
        rd_data[PEND_LSB +: NREQ]   = pend;
    end

endmodule

// File: rtl/sw_sem_arbiter_chk.sv
module sw_sem_arbiter_chk #(
    parameter int NREQ  = 4,
    parameter int REG_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [REG_W-1:0] wr_data,
    input logic [REG_W-1:0] rd_data
);

    localparam int CLR_LSB  = NREQ;
    localparam int WON_LSB  = 2 * NREQ;
    localparam int PEND_LSB = 3 * NREQ;

    logic [NREQ-1:0] c_set, c_clr, c_won, c_pend, c_clr_eff, c_cand;
    logic            unused_chk;

    assign c_set      = wr_data[0 +: NREQ];
    assign c_clr      = wr_data[CLR_LSB +: NREQ];
    assign c_won      = rd_data[WON_LSB +: NREQ];
    assign c_pend     = rd_data[PEND_LSB +: NREQ];
    assign c_clr_eff  = wr_en ? c_clr : '0;
    assign c_cand     = c_pend & ~c_clr_eff;
    assign unused_chk = ^wr_data[REG_W-1:WON_LSB];

    // R1 and R3: set without clear lands in pending
    a_r1_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((c_pend & $past(c_set & ~c_clr)) == $past(c_set & ~c_clr)));

    // R2 and R3: clear always empties pending
    a_r2_clr_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((c_pend & $past(c_clr)) == '0));

    // R1: no write, no change in pending
    a_r1_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(c_pend));

    // R5: at most one owner
    a_r5_onehot_won: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(c_won));

    // R5: owner is always pending
    a_r5_won_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (c_won & ~c_pend) == '0);

    // R6: new grant is lowest candidate
    a_r6_lowest: assert property (@(posedge clk) disable iff (!rst_n)
        (c_won == '0) |=> ((c_won == '0) || (c_won == ($past(c_cand) & (~$past(c_cand) + 1'b1)))));

    // R7: free with a candidate grants next edge
    a_r7_grant_next: assert property (@(posedge clk) disable iff (!rst_n)
        ((c_won == '0) && (c_cand != '0)) |=> (c_won != '0));

    // R7: no candidate, no grant
    a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        ((c_won == '0) && (c_cand == '0)) |=> (c_won == '0));

    // R8: grant held until owner clear
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((c_won != '0) && ((c_clr_eff & c_won) == '0)) |=> (c_won == $past(c_won)));

    // R9: owner clear releases
    a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
        ((c_won & c_clr_eff) != '0) |=> (c_won == '0));

    // R11: unused read bits are zero
    a_r11_rd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[WON_LSB-1:0] == '0) && (rd_data[REG_W-1:PEND_LSB+NREQ] == '0));

endmodule

bind sw_sem_arbiter sw_sem_arbiter_chk #(.NREQ(NREQ), .REG_W(REG_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data)
);

// File: tb/sw_sem_arbiter_tb.sv
module sw_sem_arbiter_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    sw_sem_arbiter u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data)
    );

    function automatic logic [3:0] lowest(input logic [3:0] v);
        return v & (~v + 4'd1);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n   = 1'b0;
        wr_en   = 1'b1;
        wr_data = 32'h0000_000F;
        @(negedge clk);
        wr_en   = 1'b0;
        @(negedge clk);
        rst_n   = 1'b1;
    endtask

    task automatic do_write(input logic [31:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    initial begin
        logic [3:0] won_m, pend_m, set_b, clr_b;
        do_reset();
        check("R10 reset state", rd_data, 32'h0);
        for (int p = 0; p < 16; p++) begin
            for (int w = 0; w < 256; w++) begin
                do_reset();
                check("R10 reset clears", rd_data, 32'h0);
                pend_m = p[3:0];
                won_m  = 4'h0;
                if (p != 0) begin
                    do_write({28'h0, p[3:0]});
                    // R7: grant not yet visible
                    check("R1 R4 R7 after set", rd_data, {16'h0, pend_m, 4'h0, 8'h0});
                    idle();
                    won_m = lowest(pend_m);
                    check("R6 R7 first grant", rd_data, {16'h0, pend_m, won_m, 8'h0});
                end
                set_b = w[3:0];
                clr_b = w[7:4];
                // upper bits try to overwrite read-only fields (R11)
                do_write({16'hA5C3 ^ {4{p[3:0]}}, ~w[7:0], w[7:0]});
                pend_m = (pend_m | set_b) & ~clr_b;
                if ((won_m & clr_b) != 4'h0) won_m = 4'h0;
                check("R1 R2 R3 R8 R9 R11 after write", rd_data, {16'h0, pend_m, won_m, 8'h0});
                idle();
                if (won_m == 4'h0) won_m = lowest(pend_m);
                check("R6 R8 R9 next grant", rd_data, {16'h0, pend_m, won_m, 8'h0});
            end
        end
        done = 1'b1;
    end

    initial begin
        for (int cyc = 0; cyc < 190000; cyc++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule